// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block sits beside the processor status register and decides whether the highest pending device interrupt may be taken. It holds the processor's current priority level, a small unsigned field that is 3 bits wide by default and so covers levels 0 to 7. An upstream arbiter presents one request together with that request's level. Each device's level is programmed through that device's own interrupt control register.

A request is taken only when it is valid, interrupts are not globally disabled, no level restore is under way in the same cycle, and its level is strictly greater than the current processor level. In the cycle the request is taken, the block raises `accept` for one clock and drives the level it is about to overwrite on `savedLevel`, so that a stack-push sequencer can store it. On the same clock edge the processor level takes the accepted request's level. A return-from-interrupt sequence reloads a popped level through the restore inputs. Reset clears the level to 0, so that any request with a nonzero level can then be taken.

Top module: `ipl_gate`

## Requirements
- R1: After reset `curLevel` is 0 and `accept` is 0.
- R2: `accept` is 1 in any cycle where `reqValid` is 1, `intDisable` is 0, `restoreEn` is 0 and `reqLevel` is greater than `curLevel` as an unsigned number.
- R3: A request whose level equals `curLevel` is not accepted and leaves `curLevel` unchanged.
- R4: A request whose level is below `curLevel` is not accepted and leaves `curLevel` unchanged.
- R5: While `intDisable` is 1, `accept` stays 0 and `curLevel` is not changed by any request.
- R6: In a cycle where `accept` is 1, `savedLevel` equals the value `curLevel` had before that edge. In every other cycle `savedLevel` is 0.
- R7: On the clock edge that ends an accepting cycle, `curLevel` takes the value of `reqLevel` from that cycle.
- R8: When `restoreEn` is 1, `curLevel` takes `restoreLevel` on the next edge, and `accept` is 0 in that cycle whatever the request inputs are.
- R9: A request held unchanged after it is accepted produces an `accept` pulse that lasts exactly one cycle.
- R10: When `reqValid` is 0 and `restoreEn` is 0, `accept` is 0 and `curLevel` holds its value.
- R11: A request at level 0 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A device interrupt is pending |
| reqLevel | input | LVL_W | Priority level of the pending request |
| intDisable | input | 1 | Global interrupt disable; blocks acceptance when 1 |
| restoreEn | input | 1 | Load `restoreLevel` into the processor level |
| restoreLevel | input | LVL_W | Level popped from the stack on return |
| accept | output | 1 | One-cycle strobe: the request is taken |
| savedLevel | output | LVL_W | Level to be pushed while `accept` is 1, else 0 |
| curLevel | output | LVL_W | Current processor priority level |

## Verification
On every cycle, the assertions check that the disable and restore inputs suppress `accept`, that an equal or lower level is never taken, and that the level register moves only by a take or a restore. They also check that each of these moves loads the value presented in the previous cycle, and that a held request never accepts twice in a row. The bench scenarios show the remaining behaviour: the reset value, the exact level loaded across many combinations of starting and requested levels, the pushed value seen at the port, and a restore that wins over a competing request in the same cycle.

// File: rtl/ipl_pkg.sv
package ipl_pkg;

  // Strobes from control to the level datapath
  typedef struct packed {
    logic take;     // load the request level
    logic restore;  // load the popped level
  } lvl_strobe_t;

endpackage

// File: rtl/ipl_ctrl.sv
module ipl_ctrl
  import ipl_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LVL_W-1:0] reqLevel,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             intDisable,
  input  logic             restoreEn,
  output lvl_strobe_t      strobe,
  output logic             accept
);

  logic levelAbove;
  logic gateOpen;

  // Strictly greater: an equal level does not preempt
  assign levelAbove = reqLevel > curLevel;
  // A restore owns the level register this cycle
  assign gateOpen   = !intDisable && !restoreEn;

  always_comb begin
    strobe         = '0;
    strobe.restore = restoreEn;
    strobe.take    = reqValid && gateOpen && levelAbove;
  end

  assign accept = strobe.take;

  // R5: the global disable suppresses acceptance
  a_r5_disable_blocks: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |-> !accept);

  // R8: no acceptance in a restore cycle
  a_r8_restore_blocks: assert property (@(posedge clk) disable iff (!rstN)
    restoreEn |-> !accept);

  // R3, R4: a level that is not higher is never taken
  a_r3_not_higher: assert property (@(posedge clk) disable iff (!rstN)
    (reqLevel <= curLevel) |-> !accept);

  // R10: nothing pending, nothing taken
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !accept);

  // R9: a held request is taken only once
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !(accept && reqLevel == $past(reqLevel)));

endmodule

// File: rtl/ipl_datapath.sv
module ipl_datapath
  import ipl_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  lvl_strobe_t      strobe,
  input  logic [LVL_W-1:0] reqLevel,
  input  logic [LVL_W-1:0] restoreLevel,
  output logic [LVL_W-1:0] curLevel,
  output logic [LVL_W-1:0] savedLevel
);

  localparam logic [LVL_W-1:0] LVL_RESET = '0;

  logic [LVL_W-1:0] levelQ;
  logic [LVL_W-1:0] levelD;

  always_comb begin
    levelD = levelQ;
    if (strobe.restore)   levelD = restoreLevel;
    else if (strobe.take) levelD = reqLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= LVL_RESET;
    else       levelQ <= levelD;
  end

  assign curLevel   = levelQ;
  // Old level offered to the stack pusher only while taking
  assign savedLevel = strobe.take ? levelQ : '0;

  // R7: a take loads the request level
  a_r7_take_loads: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.restore) |=> levelQ == $past(reqLevel));

  // R8: a restore loads the popped level
  a_r8_restore_loads: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restore |=> levelQ == $past(restoreLevel));

  // R10: without a strobe the level holds
  a_r10_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.take && !strobe.restore) |=> $stable(levelQ));

  // R6: the pushed value is the level before the edge
  a_r6_push_old: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> $past(savedLevel) == $past(levelQ));

endmodule

// File: rtl/ipl_gate.sv
module ipl_gate
  import ipl_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LVL_W-1:0] reqLevel,
  input  logic             intDisable,
  input  logic             restoreEn,
  input  logic [LVL_W-1:0] restoreLevel,
  output logic             accept,
  output logic [LVL_W-1:0] savedLevel,
  output logic [LVL_W-1:0] curLevel
);

  lvl_strobe_t strobe;

  ipl_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLevel   (reqLevel),
    .curLevel   (curLevel),
    .intDisable (intDisable),
    .restoreEn  (restoreEn),
    .strobe     (strobe),
    .accept     (accept)
  );

  ipl_datapath #(.LVL_W(LVL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqLevel     (reqLevel),
    .restoreLevel (restoreLevel),
    .curLevel     (curLevel),
    .savedLevel   (savedLevel)
  );

endmodule

// File: tb/ipl_gate_test.sv
module ipl_gate_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqLevel = '0;
  logic       intDisable = 1'b0;
  logic       restoreEn = 1'b0;
  logic [2:0] restoreLevel = '0;
  logic       accept;
  logic [2:0] savedLevel;
  logic [2:0] curLevel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ipl_gate #(.LVL_W(3)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel),
    .intDisable(intDisable), .restoreEn(restoreEn), .restoreLevel(restoreLevel),
    .accept(accept), .savedLevel(savedLevel), .curLevel(curLevel)
  );

  // {startLevel, valid, level, disable, expAccept, expNextLevel}
  localparam int NV = 10;
  localparam logic [NV-1:0][11:0] VEC = '{
    {3'd0, 1'b1, 3'd5, 1'b0, 1'b1, 3'd5},
    {3'd3, 1'b1, 3'd3, 1'b0, 1'b0, 3'd3},
    {3'd4, 1'b1, 3'd2, 1'b0, 1'b0, 3'd4},
    {3'd2, 1'b1, 3'd6, 1'b1, 1'b0, 3'd2},
    {3'd6, 1'b1, 3'd7, 1'b0, 1'b1, 3'd7},
    {3'd0, 1'b0, 3'd7, 1'b0, 1'b0, 3'd0},
    {3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 3'd0},
    {3'd7, 1'b1, 3'd7, 1'b0, 1'b0, 3'd7},
    {3'd1, 1'b1, 3'd2, 1'b0, 1'b1, 3'd2},
    {3'd5, 1'b1, 3'd4, 1'b1, 1'b0, 3'd5}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Step past a rising edge; inputs change and outputs are read here
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setLevel(input logic [2:0] lvl);
    reqValid = 1'b0; intDisable = 1'b0;
    restoreEn = 1'b1; restoreLevel = lvl;
    tick();
    restoreEn = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1: reset state
    check("R1 curLevel", curLevel, 0);
    check("R1 accept", accept, 0);
    rstN = 1'b1;
    tick();
    check("R1 curLevel after release", curLevel, 0);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      string tag;
      v = VEC[i];
      setLevel(v[11:9]);
      reqValid = v[8]; reqLevel = v[7:5]; intDisable = v[4];
      if (v[4])                tag = "R5";
      else if (!v[8])          tag = "R10";
      else if (v[7:5] == 3'd0) tag = "R11";
      else if (v[7:5] == v[11:9]) tag = "R3";
      else if (v[7:5] < v[11:9])  tag = "R4";
      else                     tag = "R2";
      #1;
      check({tag, " accept"}, accept, v[3]);
      check("R6 savedLevel", savedLevel, v[3] ? v[11:9] : 3'd0);
      tick();
      reqValid = 1'b0; intDisable = 1'b0;
      check({(v[3] ? "R7" : tag), " next level"}, curLevel, v[2:0]);
    end

    // R8: restore wins over a competing request
    setLevel(3'd0);
    reqValid = 1'b1; reqLevel = 3'd5;
    restoreEn = 1'b1; restoreLevel = 3'd2;
    #1;
    check("R8 accept during restore", accept, 0);
    tick();
    restoreEn = 1'b0; reqValid = 1'b0;
    check("R8 restored level", curLevel, 2);

    // R9: held request gives a single-cycle pulse
    setLevel(3'd1);
    reqValid = 1'b1; reqLevel = 3'd4;
    #1;
    check("R9 first cycle accept", accept, 1);
    tick();
    check("R9 second cycle accept", accept, 0);
    check("R9 level", curLevel, 4);
    check("R6 savedLevel idle", savedLevel, 0);
    tick();
    check("R9 third cycle accept", accept, 0);
    reqValid = 1'b0;

    // R1: reset mid-run clears the level
    rstN = 1'b0;
    #1;
    check("R1 async clear", curLevel, 0);
    tick();
    rstN = 1'b1;
    tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule